// File: doc/BRIEF.md
# Bidirectional Doorbell Interrupt Controller

This block is the interrupt meeting point between an external host and an on-chip processor. Each side reaches it through its own simple byte-wide register port: an address, a write strobe, write data and combinational read data. The host rings eight doorbells toward the processor. Each doorbell drives one processor interrupt line until the processor acknowledges it. In the other direction, the processor posts eight general events for the host, and three semaphore-grant pulses add three more. The host acknowledges these events by writing ones.

Every pending host-bound event passes through its own enable bit. The enabled events are ORed into one host interrupt line. This line comes from a two-state machine: `IRQ_QUIET` moves to `IRQ_RAISED` when any enabled event is pending, and `IRQ_RAISED` moves back to `IRQ_QUIET` when none is pending. Because the line is registered, it trails the pending and enable state by one clock. A sticky watchdog flag is also readable. Only the power-on reset clears it.

Both ports share one address map. At 0x0E, bit 0 is the watchdog flag. At 0x0F are the doorbells. The enables are at 0x11 (general) and 0x12 (semaphores, bits 2:0). The general pending bits are at 0x13 and the semaphore pending bits at 0x14 (bits 2:0). All other addresses read as zero.

Top module: `doorbell_xchg`

## Requirements
- R1: A host write to 0x0F sets every doorbell bit whose written bit is 1. Written 0 bits leave their doorbell unchanged.
- R2: Each doorbell bit drives p_irq bit i and reads back as 1 on both ports until the processor writes 1 to that bit at 0x0F. It reads 0 after that.
- R3: A processor write of 1s to 0x13 sets the matching general pending bits. Both ports read these bits at 0x13.
- R4: A host write of 1s to 0x13 clears the matching general pending bits. A host write of 1s to bits 2:0 of 0x14 clears the matching semaphore pending bits. Written 0s have no effect.
- R5: A pulse on sem_grant bit i sets bit i of 0x14. Bits 7:3 of 0x14 always read 0, and a processor write to 0x14 changes nothing.
- R6: h_irq equals the OR over all eleven pending bits ANDed with their enables, delayed by exactly one clock.
- R7: The enables are processor-writable. 0x11 bits 7:0 gate the general events and 0x12 bits 2:0 gate semaphores 0 to 2. The host can read them, but host writes to 0x11 and 0x12 are ignored.
- R8: When a set and a clear hit the same bit in the same clock, the bit ends up set. This applies to doorbells and to pending bits.
- R9: While rst_n is low, doorbells, pending bits, enables and h_irq are all 0. Unmapped addresses read 0.
- R10: A wdog_pulse sets bit 0 of 0x0E. The flag stays set through rst_n, and only por_n clears it. Bits 7:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the watchdog flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears all other state |
| wdog_pulse | input | 1 | Watchdog-reset event |
| sem_grant | input | 3 | Semaphore-granted pulses, one per semaphore |
| h_addr | input | 8 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| p_addr | input | 8 | Processor register address |
| p_wr | input | 1 | Processor write strobe |
| p_wdata | input | 8 | Processor write data |
| p_rdata | output | 8 | Processor read data |
| p_irq | output | 8 | Doorbell interrupt lines to the processor |
| h_irq | output | 1 | Combined interrupt line to the host |

## Verification
The assertions check, on every clock, that h_irq trails the masked OR by one cycle and that a grant pulse is never lost, including when a host clear hits the same bit. They also check that doorbells appear only after a host write and vanish only after a processor clear, that reserved bits read 0, and that the watchdog flag is sticky. Some behaviours can only be shown by the bench scenarios, because they depend on a chosen sequence of writes on both ports: that host writes to the enables are ignored, that processor writes to 0x14 have no effect, that the watchdog flag survives rst_n, and that enable masking suppresses h_irq.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OFS_WDOG  = 8'h0E;
    localparam logic [7:0] OFS_DOOR  = 8'h0F;
    localparam logic [7:0] OFS_EN_G  = 8'h11;
    localparam logic [7:0] OFS_EN_S  = 8'h12;
    localparam logic [7:0] OFS_SRC_G = 8'h13;
    localparam logic [7:0] OFS_SRC_S = 8'h14;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/db_pend_bank.sv
module db_pend_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // set has priority over clear in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/db_irq_fsm.sv
module db_irq_fsm
    import doorbell_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    irq_state_e state_q, state_d;
    logic       any_live;

    assign any_live = |(pend_i & en_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_live)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_live) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/db_wdog_latch.sv
module db_wdog_latch (
    input  logic clk,
    input  logic por_n,
    input  logic evt_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     flag_o <= 1'b0;
        else if (evt_i) flag_o <= 1'b1;
    end
endmodule

// File: rtl/doorbell_xchg.sv
module doorbell_xchg
    import doorbell_pkg::*;
#(
    parameter int N_DOOR = 8,
    parameter int N_GEN  = 8,
    parameter int N_SEM  = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wdog_pulse,
    input  logic [N_SEM-1:0] sem_grant,
    input  logic [7:0]       h_addr,
    input  logic             h_wr,
    input  logic [7:0]       h_wdata,
    output logic [7:0]       h_rdata,
    input  logic [7:0]       p_addr,
    input  logic             p_wr,
    input  logic [7:0]       p_wdata,
    output logic [7:0]       p_rdata,
    output logic [N_DOOR-1:0] p_irq,
    output logic             h_irq
);
    localparam int N_SRC = N_GEN + N_SEM;

    logic [N_DOOR-1:0] door_q, door_set, door_clr;
    logic [N_SRC-1:0]  src_q, src_set, src_clr;
    logic [N_SRC-1:0]  en_q;
    logic              wdog_flag;

    // write decodes
    logic h_we_door, h_we_srcg, h_we_srcs;
    logic p_we_door, p_we_srcg, p_we_eng, p_we_ens;

    assign h_we_door = h_wr && (h_addr == OFS_DOOR);
    assign h_we_srcg = h_wr && (h_addr == OFS_SRC_G);
    assign h_we_srcs = h_wr && (h_addr == OFS_SRC_S);
    assign p_we_door = p_wr && (p_addr == OFS_DOOR);
    assign p_we_srcg = p_wr && (p_addr == OFS_SRC_G);
    assign p_we_eng  = p_wr && (p_addr == OFS_EN_G);
    assign p_we_ens  = p_wr && (p_addr == OFS_EN_S);

    assign door_set = h_we_door ? h_wdata[N_DOOR-1:0] : '0;
    assign door_clr = p_we_door ? p_wdata[N_DOOR-1:0] : '0;

    assign src_set = {sem_grant, (p_we_srcg ? p_wdata[N_GEN-1:0] : {N_GEN{1'b0}})};
    assign src_clr = {(h_we_srcs ? h_wdata[N_SEM-1:0] : {N_SEM{1'b0}}),
                      (h_we_srcg ? h_wdata[N_GEN-1:0] : {N_GEN{1'b0}})};

    db_pend_bank #(.W(N_DOOR)) u_door (
        .clk(clk), .rst_n(rst_n), .set_i(door_set), .clr_i(door_clr), .q_o(door_q)
    );

    db_pend_bank #(.W(N_SRC)) u_src (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr), .q_o(src_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (p_we_eng) en_q[N_GEN-1:0]     <= p_wdata[N_GEN-1:0];
            if (p_we_ens) en_q[N_SRC-1:N_GEN] <= p_wdata[N_SEM-1:0];
        end
    end

    db_irq_fsm #(.W(N_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .pend_i(src_q), .en_i(en_q), .irq_o(h_irq)
    );

    db_wdog_latch u_wdog (
        .clk(clk), .por_n(por_n), .evt_i(wdog_pulse), .flag_o(wdog_flag)
    );

    assign p_irq = door_q;

    // byte views of each register, reserved bits zero
    logic [7:0] b_wdog, b_door, b_eng, b_ens, b_srcg, b_srcs;
    always_comb begin
        b_wdog = '0; b_door = '0; b_eng = '0;
        b_ens  = '0; b_srcg = '0; b_srcs = '0;
        b_wdog[0]          = wdog_flag;
        b_door[N_DOOR-1:0] = door_q;
        b_eng[N_GEN-1:0]   = en_q[N_GEN-1:0];
        b_ens[N_SEM-1:0]   = en_q[N_SRC-1:N_GEN];
        b_srcg[N_GEN-1:0]  = src_q[N_GEN-1:0];
        b_srcs[N_SEM-1:0]  = src_q[N_SRC-1:N_GEN];
    end

    logic [7:0] rd_ports [2];
    logic [7:0] addr_ports [2];
    assign addr_ports[0] = h_addr;
    assign addr_ports[1] = p_addr;

    for (genvar g = 0; g < 2; g++) begin : g_rd
        always_comb begin
            unique case (addr_ports[g])
                OFS_WDOG:  rd_ports[g] = b_wdog;
                OFS_DOOR:  rd_ports[g] = b_door;
                OFS_EN_G:  rd_ports[g] = b_eng;
                OFS_EN_S:  rd_ports[g] = b_ens;
                OFS_SRC_G: rd_ports[g] = b_srcg;
                OFS_SRC_S: rd_ports[g] = b_srcs;
                default:   rd_ports[g] = '0;
            endcase
        end
    end

    assign h_rdata = rd_ports[0];
    assign p_rdata = rd_ports[1];
endmodule

// File: rtl/doorbell_xchg_chk.sv
module doorbell_xchg_chk #(
    parameter int N_DOOR = 8,
    parameter int N_SRC  = 11,
    parameter int N_SEM  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic [N_SRC-1:0]  pend,
    input logic [N_SRC-1:0]  en,
    input logic              h_irq,
    input logic [N_DOOR-1:0] p_irq,
    input logic [N_SEM-1:0]  sem_grant,
    input logic              h_wr,
    input logic [7:0]        h_addr,
    input logic [7:0]        h_rdata,
    input logic              p_wr,
    input logic [7:0]        p_addr,
    input logic              wdog_flag
);
    a_r6_irq_lags_mask: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (h_irq == $past(|(pend & en))));

    a_r8_grant_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_grant != '0) |=> ((pend[N_SRC-1:N_SRC-N_SEM] & $past(sem_grant)) == $past(sem_grant)));

    a_r2_door_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_wr && p_addr == 8'h0F) |=> ((p_irq & $past(p_irq)) == $past(p_irq)));

    a_r1_door_only_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_wr && h_addr == 8'h0F) |=> ((p_irq & ~$past(p_irq)) == '0));

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (h_addr == 8'h14) |-> (h_rdata[7:3] == 5'd0));

    a_r10_wdog_sticky: assert property (@(posedge clk) disable iff (!por_n)
        wdog_flag |=> wdog_flag);
endmodule

bind doorbell_xchg doorbell_xchg_chk #(
    .N_DOOR(N_DOOR), .N_SRC(N_GEN + N_SEM), .N_SEM(N_SEM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .pend(src_q), .en(en_q),
    .h_irq(h_irq), .p_irq(p_irq), .sem_grant(sem_grant), .h_wr(h_wr),
    .h_addr(h_addr), .h_rdata(h_rdata), .p_wr(p_wr), .p_addr(p_addr),
    .wdog_flag(wdog_flag)
);

// File: tb/doorbell_xchg_bench.sv
module doorbell_xchg_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0, wdog_pulse = 1'b0;
    logic [2:0] sem_grant = '0;
    logic [7:0] h_addr = '0, h_wdata = '0, p_addr = '0, p_wdata = '0;
    logic       h_wr = 1'b0, p_wr = 1'b0;
    logic [7:0] h_rdata, p_rdata, p_irq;
    logic       h_irq;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    doorbell_xchg u_doorbell_xchg (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wdog_pulse(wdog_pulse),
        .sem_grant(sem_grant), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .p_addr(p_addr), .p_wr(p_wr), .p_wdata(p_wdata),
        .p_rdata(p_rdata), .p_irq(p_irq), .h_irq(h_irq)
    );

    // behavioural reference model
    logic [7:0]  m_door = '0;
    logic [10:0] m_src = '0, m_en = '0;
    logic        m_irq = 1'b0, m_wd = 1'b0;

    always @(posedge clk or negedge rst_n or negedge por_n) begin
        if (!por_n) m_wd = 1'b0;
        if (!rst_n) begin
            m_door = '0; m_src = '0; m_en = '0; m_irq = 1'b0;
        end else if (clk) begin
            m_irq = |(m_src & m_en);
            if (p_wr && p_addr == 8'h0F) m_door = m_door & ~p_wdata;
            if (h_wr && h_addr == 8'h0F) m_door = m_door | h_wdata;
            if (h_wr && h_addr == 8'h13) m_src[7:0]  = m_src[7:0]  & ~h_wdata;
            if (h_wr && h_addr == 8'h14) m_src[10:8] = m_src[10:8] & ~h_wdata[2:0];
            if (p_wr && p_addr == 8'h13) m_src[7:0]  = m_src[7:0]  | p_wdata;
            m_src[10:8] = m_src[10:8] | sem_grant;
            if (p_wr && p_addr == 8'h11) m_en[7:0]  = p_wdata;
            if (p_wr && p_addr == 8'h12) m_en[10:8] = p_wdata[2:0];
        end
        if (por_n && clk && wdog_pulse) m_wd = 1'b1;
    end

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h0E:   return {7'd0, m_wd};
            8'h0F:   return m_door;
            8'h11:   return m_en[7:0];
            8'h12:   return {5'd0, m_en[10:8]};
            8'h13:   return m_src[7:0];
            8'h14:   return {5'd0, m_src[10:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h0E:        return "R10";
            8'h0F:        return "R1";
            8'h11, 8'h12: return "R7";
            8'h13:        return "R3";
            8'h14:        return "R5";
            default:      return "R9";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        check(p_irq === m_door, rst_n ? "R2" : "R9", p_irq, m_door);
        check(h_irq === m_irq, rst_n ? "R6" : "R9", {7'd0, h_irq}, {7'd0, m_irq});
        check(h_rdata === m_read(h_addr), tag_of(h_addr), h_rdata, m_read(h_addr));
        check(p_rdata === m_read(p_addr), tag_of(p_addr), p_rdata, m_read(p_addr));
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
        h_wr = 1'b0; p_wr = 1'b0; sem_grant = '0; wdog_pulse = 1'b0;
    endtask

    task automatic hw(input logic [7:0] a, input logic [7:0] d);
        h_addr = a; h_wdata = d; h_wr = 1'b1; step();
    endtask

    task automatic pw(input logic [7:0] a, input logic [7:0] d);
        p_addr = a; p_wdata = d; p_wr = 1'b1; step();
    endtask

    task automatic hpeek(input logic [7:0] a, input logic [7:0] exp, input string req);
        h_addr = a;
        @(negedge clk);
        check(h_rdata === exp, req, h_rdata, exp);
        step();
    endtask

    initial begin
        step(); step();
        hpeek(8'h13, 8'h00, "R9");
        check(h_irq === 1'b0, "R9", {7'd0, h_irq}, 8'h00);
        #1 por_n = 1'b1; rst_n = 1'b1;
        step();
        hpeek(8'h20, 8'h00, "R9");

        // R1 R2 doorbells
        hw(8'h0F, 8'hA5);
        hpeek(8'h0F, 8'hA5, "R1");
        hw(8'h0F, 8'h00);
        hpeek(8'h0F, 8'hA5, "R1");
        pw(8'h0F, 8'h05);
        hpeek(8'h0F, 8'hA0, "R2");
        // R8 simultaneous set and clear on a doorbell
        h_addr = 8'h0F; h_wdata = 8'h80; h_wr = 1'b1;
        p_addr = 8'h0F; p_wdata = 8'hFF; p_wr = 1'b1;
        step();
        hpeek(8'h0F, 8'h80, "R8");

        // R7 host cannot write enables
        hw(8'h11, 8'hFF);
        hpeek(8'h11, 8'h00, "R7");
        // R3 R6 general source with enable masking
        pw(8'h13, 8'h3C);
        hpeek(8'h13, 8'h3C, "R3");
        check(h_irq === 1'b0, "R6", {7'd0, h_irq}, 8'h00);
        pw(8'h11, 8'h04);
        step();
        check(h_irq === 1'b1, "R6", {7'd0, h_irq}, 8'h01);
        // R4 host clear
        hw(8'h13, 8'h0C);
        hpeek(8'h13, 8'h30, "R4");
        step();
        check(h_irq === 1'b0, "R6", {7'd0, h_irq}, 8'h00);

        // R5 semaphore grants
        sem_grant = 3'b101; step();
        hpeek(8'h14, 8'h05, "R5");
        pw(8'h14, 8'hFF);
        hpeek(8'h14, 8'h05, "R5");
        pw(8'h12, 8'h01);
        step();
        check(h_irq === 1'b1, "R6", {7'd0, h_irq}, 8'h01);
        hw(8'h14, 8'h01);
        hpeek(8'h14, 8'h04, "R4");
        // R8 grant beats host clear
        h_addr = 8'h14; h_wdata = 8'h07; h_wr = 1'b1; sem_grant = 3'b010;
        step();
        hpeek(8'h14, 8'h02, "R8");

        // R10 watchdog flag
        wdog_pulse = 1'b1; step();
        hpeek(8'h0E, 8'h01, "R10");
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        hpeek(8'h0E, 8'h01, "R10");
        hpeek(8'h13, 8'h00, "R9");
        por_n = 1'b0; rst_n = 1'b0; step();
        por_n = 1'b1; rst_n = 1'b1; step();
        hpeek(8'h0E, 8'h00, "R10");

        // a mixed pattern
        for (int i = 0; i < 40; i++) begin
            h_addr = 8'h0E + 8'(i % 7); h_wdata = 8'(i * 37); h_wr = (i % 3 == 0);
            p_addr = 8'h0F + 8'(i % 6); p_wdata = 8'(i * 53); p_wr = (i % 4 == 1);
            sem_grant = 3'(i % 5);
            step();
        end
        step(); step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule